// File: doc/BRIEF.md
# UART Receive Status and Flag Controller

This block holds the receive-side status of a serial port. It sits between a receive shift engine and a CPU bus. The shift engine marks the end of each frame with a single-cycle strobe. With the strobe it passes the received byte and three quality indications: noise seen while sampling, a low stop bit, and a parity mismatch. The block keeps a one-byte receive data register and five sticky flags: receive-full, overrun, noise, framing and parity. It drives two registered interrupt requests. The data-ready request follows the receive-full flag. The error request is the OR of the four error flags, each gated by its own enable bit.

Software clears the flags in two steps. A read of the status register arms a clear for each flag that is set at that moment. A later read of the data register then clears exactly the armed flags. A flag that sets between the two reads survives and needs a new status read. If a byte completes while the receive-full flag is still set, the new byte is lost and the overrun flag sets. The older byte stays readable. After the late clear sequence, the next byte is taken in normally.

Top module: `uart_rx_status`

## Requirements
- R1: After synchronous reset, every flag, every enable bit, the held byte, `bus_rdata`, `irq_data` and `irq_err` are zero.
- R2: A `rx_done` strobe while receive-full is clear loads `rx_byte` into the data register and sets receive-full. The status register is at address 0, with receive-full at bit 0.
- R3: A `rx_done` strobe while receive-full is set, and not being cleared in that cycle, sets the overrun flag (status bit 1). The new byte is discarded and the data register keeps the older byte.
- R4: The noise flag (status bit 2) sets when a byte is accepted with `rx_noise` high.
- R5: The framing flag (status bit 3) sets when a byte is accepted with `rx_frame_err` high, which means the stop-bit sample was 0.
- R6: The parity flag (status bit 4) sets when a byte is accepted with `rx_par_err` high.
- R7: A read of the data register (address 1) clears each flag that was set at the most recent status read since the last data read. A data read with no status read before it leaves the flags unchanged.
- R8: A flag that sets after the status read is not cleared by the following data read. Control-register accesses between the two reads do not cancel the armed clear.
- R9: After the delayed sequence, the next byte is accepted normally. In that sequence the status read shows overrun set, and the data read returns the older byte and clears overrun.
- R10: One cycle after the flags change, `irq_data` equals receive-full AND enable bit 0. In the same way, `irq_err` equals the OR over bits 1 to 4 of flag AND enable.
- R11: The control register is at address 2, and its bits [4:0] are the enables, in the same bit order as the status flags. It is written with `bus_wr` and reads back its value. Address 3 reads 0. `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value when there is no read.
- R12: A data read that clears receive-full in the same cycle as a `rx_done` strobe accepts the new byte. The read returns the old byte, and receive-full stays set.
- R13: The quality indications of a byte discarded by overrun set no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | Frame-complete strobe from the shift engine |
| rx_byte | input | DATA_W | Received byte, valid with `rx_done` |
| rx_noise | input | 1 | Noise seen during the frame, valid with `rx_done` |
| rx_frame_err | input | 1 | Stop-bit sample was low, valid with `rx_done` |
| rx_par_err | input | 1 | Parity mismatch, valid with `rx_done` |
| bus_addr | input | ADDR_W | Register address: 0 status, 1 data, 2 control |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (control register only) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_data | output | 1 | Data-ready interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
Flags, the held byte and `bus_rdata` change on the edge that samples the strobe, so each is due one cycle after the stimulus. The interrupt requests are due one edge later, because they are registered from the flags. The bench drives its inputs on falling edges. A behavioural model advances on every rising edge and is compared with the outputs on the next falling edge, so each result is checked in the cycle it is due. Directed reads check the status and data values at the points where the corner cases settle.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int NFLAG = 5;
  localparam int F_FULL = 0;
  localparam int F_OVR  = 1;
  localparam int F_NSE  = 2;
  localparam int F_FRM  = 3;
  localparam int F_PAR  = 4;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_DATA = 2'd1,
    A_CTRL = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic snap_i,
  input  logic take_i,
  output logic clr_o,
  output logic flag_o
);
  logic armed_q;
  logic flag_q;

  assign clr_o  = take_i & armed_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= (flag_q & ~clr_o) | set_i;
      if (take_i)      armed_q <= 1'b0;
      else if (snap_i) armed_q <= flag_q;
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (take_i && armed_q && !set_i) |=> !flag_o);
  assert_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (take_i && !armed_q && flag_o) |=> flag_o);
  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
endmodule

// File: rtl/rxs_hold_reg.sv
module rxs_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst)         byte_q <= '0;
    else if (load_i) byte_q <= din_i;
  end
  assign dout_o = byte_q;

  assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(dout_o));
endmodule

// File: rtl/rxs_bus_port.sv
module rxs_bus_port
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NFLAG-1:0]  flags_i,
  input  logic [DATA_W-1:0] held_i,
  output logic [NFLAG-1:0]  en_o,
  output logic              stat_rd_o,
  output logic              data_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NFLAG-1:0]  en_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] mux;

  assign stat_rd_o = rd_i && (addr_i == ADDR_W'(A_STAT));
  assign data_rd_o = rd_i && (addr_i == ADDR_W'(A_DATA));

  always_comb begin
    mux = '0;
    case (addr_i)
      ADDR_W'(A_STAT): mux = DATA_W'(flags_i);
      ADDR_W'(A_DATA): mux = held_i;
      ADDR_W'(A_CTRL): mux = DATA_W'(en_q);
      default:         mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_W'(A_CTRL)) en_q <= wdata_i[NFLAG-1:0];
      if (rd_i) rdata_q <= mux;
    end
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !(stat_rd_o && data_rd_o));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_noise,
  input  logic              rx_frame_err,
  input  logic              rx_par_err,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_data,
  output logic              irq_err
);
  logic [NFLAG-1:0]  flags, setv, clrs, en;
  logic [DATA_W-1:0] held;
  logic              stat_rd, data_rd, still_full, accept, lost;
  logic              irq_data_q, irq_err_q;

  assign still_full = flags[F_FULL] & ~clrs[F_FULL];
  assign accept     = rx_done & ~still_full;
  assign lost       = rx_done & still_full;

  assign setv[F_FULL] = accept;
  assign setv[F_OVR]  = lost;
  assign setv[F_NSE]  = accept & rx_noise;
  assign setv[F_FRM]  = accept & rx_frame_err;
  assign setv[F_PAR]  = accept & rx_par_err;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rxs_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (setv[i]),
      .snap_i (stat_rd),
      .take_i (data_rd),
      .clr_o  (clrs[i]),
      .flag_o (flags[i])
    );
  end

  rxs_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .din_i  (rx_byte),
    .dout_o (held)
  );

  rxs_bus_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (bus_addr),
    .rd_i      (bus_rd),
    .wr_i      (bus_wr),
    .wdata_i   (bus_wdata),
    .flags_i   (flags),
    .held_i    (held),
    .en_o      (en),
    .stat_rd_o (stat_rd),
    .data_rd_o (data_rd),
    .rdata_o   (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_data_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      irq_data_q <= flags[F_FULL] & en[F_FULL];
      irq_err_q  <= |(flags[NFLAG-1:F_OVR] & en[NFLAG-1:F_OVR]);
    end
  end
  assign irq_data = irq_data_q;
  assign irq_err  = irq_err_q;

  assert_irq_err_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_err == $past(|(flags[NFLAG-1:F_OVR] & en[NFLAG-1:F_OVR])));
  assert_irq_data_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_data == $past(flags[F_FULL] & en[F_FULL]));
  assert_overrun_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_done && flags[F_FULL] && !data_rd) |=> flags[F_OVR] && $stable(held));
  assert_lost_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    (lost && !flags[F_NSE] && !data_rd) |=> !flags[F_NSE]);
endmodule

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_done = 0, rx_noise = 0, rx_frame_err = 0, rx_par_err = 0;
  logic [7:0] rx_byte = '0;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_data, irq_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_rx_status dut (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte),
    .rx_noise(rx_noise), .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_data(irq_data), .irq_err(irq_err)
  );

  // behavioural reference: flags and arms as bit lists by status position
  bit [4:0] m_flag, m_arm, m_en;
  bit [7:0] m_byte, m_rd;
  bit       m_irqd, m_irqe;

  always @(posedge clk) begin
    bit [4:0] clr, nf;
    bit full_left, take, drop;
    if (rst) begin
      m_flag = 0; m_arm = 0; m_en = 0; m_byte = 0; m_rd = 0;
      m_irqd = 0; m_irqe = 0;
    end else begin
      clr = (bus_rd && bus_addr == 2'd1) ? (m_arm & m_flag) : 5'd0;
      full_left = m_flag[0] && !clr[0];
      take = rx_done && !full_left;
      drop = rx_done && full_left;
      m_irqd = m_flag[0] && m_en[0];
      m_irqe = (m_flag[4:1] & m_en[4:1]) != 0;
      if (bus_rd) begin
        if (bus_addr == 2'd0) m_rd = {3'b0, m_flag};
        else if (bus_addr == 2'd1) m_rd = m_byte;
        else if (bus_addr == 2'd2) m_rd = {3'b0, m_en};
        else m_rd = 0;
      end
      nf = m_flag & ~clr;
      if (take) begin
        nf[0] = 1; m_byte = rx_byte;
        if (rx_noise) nf[2] = 1;
        if (rx_frame_err) nf[3] = 1;
        if (rx_par_err) nf[4] = 1;
      end
      if (drop) nf[1] = 1;
      if (bus_rd && bus_addr == 2'd1) m_arm = 0;
      else if (bus_rd && bus_addr == 2'd0) m_arm = m_flag;
      if (bus_wr && bus_addr == 2'd2) m_en = bus_wdata[4:0];
      m_flag = nf;
    end
  end

  // per-clock comparison against the model (R10 interrupts, R11 read data)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (bus_rdata !== m_rd || irq_data !== m_irqd || irq_err !== m_irqe) begin
        fails++;
        $display("FAIL R10 R11 per-cycle: rdata=%h irqd=%b irqe=%b expected rdata=%h irqd=%b irqe=%b",
                 bus_rdata, irq_data, irq_err, m_rd, m_irqd, m_irqe);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic send(input bit [7:0] b, input bit n, input bit f, input bit p);
    rx_done = 1; rx_byte = b; rx_noise = n; rx_frame_err = f; rx_par_err = p;
    tick();
    rx_done = 0; rx_noise = 0; rx_frame_err = 0; rx_par_err = 0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [7:0] v);
    bus_rd = 1; bus_addr = a;
    tick();
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic wr(input bit [7:0] d);
    bus_wr = 1; bus_addr = 2'd2; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [7:0] v;
    tick(); tick(); rst = 0; tick();
    // R1
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", {irq_data, irq_err}, 0);
    rd(2'd0, v); chk("R1 status", v, 0);
    rd(2'd2, v); chk("R1 enables", v, 0);
    // R11
    wr(8'h1F); rd(2'd2, v); chk("R11 ctrl readback", v, 8'h1F);
    rd(2'd3, v); chk("R11 unused addr", v, 0);
    // R2 and R7 without arming
    send(8'hA5, 0, 0, 0);
    rd(2'd0, v); chk("R2 full", v, 8'h01);
    chk("R10 irq_data", irq_data, 1);
    wr(8'h1F);
    rd(2'd1, v); chk("R2 data", v, 8'hA5);
    // that data read had an intervening write but an arm from the status read
    rd(2'd0, v); chk("R7 cleared", v, 8'h00);
    send(8'h5A, 0, 0, 0);
    rd(2'd1, v); rd(2'd0, v); chk("R7 unarmed read keeps", v, 8'h01);
    rd(2'd1, v); rd(2'd0, v); chk("R7 clear", v, 0);
    // R4 with interrupt gating
    send(8'h11, 1, 0, 0); tick();
    rd(2'd0, v); chk("R4 noise", v, 8'h05);
    chk("R10 irq_err on", irq_err, 1);
    wr(8'h1B); tick();
    chk("R10 irq_err gated", irq_err, 0);
    wr(8'h1F);
    rd(2'd0, v); rd(2'd1, v); rd(2'd0, v); chk("R7 noise clear", v, 0);
    // R5, R6
    send(8'h22, 0, 1, 0);
    rd(2'd0, v); chk("R5 framing", v, 8'h09);
    rd(2'd1, v);
    send(8'h33, 0, 0, 1);
    rd(2'd0, v); chk("R6 parity", v, 8'h11);
    rd(2'd1, v); rd(2'd0, v); chk("R7 multi clear", v, 0);
    // R3, R13
    send(8'h44, 0, 0, 0);
    send(8'h55, 1, 1, 1);
    rd(2'd0, v); chk("R3 R13 overrun only", v, 8'h03);
    rd(2'd1, v); chk("R3 older byte kept", v, 8'h44);
    rd(2'd0, v); chk("R7 overrun clear", v, 0);
    // R9 with R8
    send(8'h66, 0, 0, 0);
    rd(2'd0, v); chk("R9 first status", v, 8'h01);
    send(8'h77, 0, 0, 0);
    rd(2'd1, v); chk("R8 data after late byte", v, 8'h66);
    rd(2'd0, v); chk("R8 late overrun survives", v, 8'h02);
    wr(8'h1F); rd(2'd2, v);
    rd(2'd1, v); chk("R9 data returns older", v, 8'h66);
    rd(2'd0, v); chk("R9 overrun cleared", v, 0);
    send(8'h88, 0, 0, 0);
    rd(2'd0, v); chk("R9 next accepted", v, 8'h01);
    rd(2'd1, v); chk("R9 next byte", v, 8'h88);
    // R12
    send(8'h99, 0, 0, 0);
    rd(2'd0, v);
    bus_rd = 1; bus_addr = 2'd1; rx_done = 1; rx_byte = 8'hAB;
    tick();
    bus_rd = 0; rx_done = 0;
    chk("R12 read returns old", bus_rdata, 8'h99);
    rd(2'd0, v); chk("R12 full stays", v, 8'h01);
    rd(2'd1, v); chk("R12 new byte", v, 8'hAB);
    tick(); tick();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule